// File: doc/BRIEF.md
# Up/Down Auto-Reload Square-Wave Timer

This block is a reloading timer that advances once per clock-enable tick, counting either upward or downward, and inverts a square-wave output every time it reaches its terminal state. Counting up, it climbs to all-ones and then restarts from a programmable reload value. Counting down, it falls until the count equals the reload value and then restarts from all-ones. Both directions pass through the same number of states, `2^CNT_W - reload`, per half period. The output therefore has a 50% duty cycle and a frequency of tick rate / (2 × (2^CNT_W − reload)) in either direction.

Software sets the reload value, the direction, a run bit, the output enable and two mode selects. The timer advances only when the block is in reload mode: both the capture select and the external-counter select must be zero. The toggle state can be read at any time. A software write to it forces the level, so the waveform can start from a chosen level or be parked at one. On the tick that reloads the counter, a single-cycle event flag is raised.

Top module: `toggle_timer`

## Requirements
- R1: In up mode (`cfg_down`=0), each advancing tick adds one to `count_o`. A tick taken while `count_o` is all-ones loads `cfg_reload` instead.
- R2: In down mode (`cfg_down`=1), each advancing tick subtracts one from `count_o` (0 wraps to all-ones). A tick taken while `count_o` equals `cfg_reload` loads all-ones instead.
- R3: `event_o` is high for exactly the one cycle that follows a reloading tick, and is low in every other cycle.
- R4: Each reloading tick inverts `tgl_state_o`, unless a software write happens in the same cycle.
- R5: In both directions, `tgl_state_o` changes once every `2^CNT_W - cfg_reload` advancing ticks.
- R6: The counter advances only when `tick_en`=1, `cfg_run`=1, `cfg_capture_sel`=0 and `cfg_counter_sel`=0. In any other cycle, `count_o` and `tgl_state_o` hold their values.
- R7: `pin_o` equals `tgl_state_o` when `cfg_oe`=1, and is 0 when `cfg_oe`=0.
- R8: When `tgl_wr_en`=1, `tgl_state_o` takes `tgl_wr_val` in the next cycle. This write takes priority over a reloading tick in the same cycle.
- R9: A change of `cfg_down` does not alter `count_o` by itself. The next advancing tick steps the count in the new direction.
- R10: After reset, `count_o`=0, `event_o`=0, `tgl_state_o`=0 and `pin_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Clock-enable tick that paces the counter |
| cfg_reload | input | CNT_W | Reload value (up mode) / match value (down mode) |
| cfg_down | input | 1 | Count direction: 0 up, 1 down |
| cfg_run | input | 1 | Run bit |
| cfg_oe | input | 1 | Output enable for `pin_o` |
| cfg_capture_sel | input | 1 | Capture select; must be 0 for reload mode |
| cfg_counter_sel | input | 1 | External-counter select; must be 0 for timer mode |
| tgl_wr_en | input | 1 | Software write strobe for the toggle state |
| tgl_wr_val | input | 1 | Value written into the toggle state |
| count_o | output | CNT_W | Current count |
| event_o | output | 1 | One-cycle overflow/underflow flag |
| tgl_state_o | output | 1 | Readable toggle state |
| pin_o | output | 1 | Square-wave pin level |

## Verification
The bench builds the block with `CNT_W` = 8, so a full pass from reset through all-ones takes only 256 ticks. At that width, the up-mode rollover, the down-mode match and reload, and several complete square-wave half periods all fit in a short directed run. Reload values near the top of the range (0xF0 and 0xF8) give half periods of 16 and 8 ticks. These short periods let the bench count exact toggle spacing in both directions and place a software write on the very tick where a reload happens.

// File: rtl/toggle_timer_pkg.sv
package toggle_timer_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } tt_dir_e;

    typedef enum logic [1:0] {
        MODE_RELOAD_TIMER = 2'b00,
        MODE_RELOAD_COUNT = 2'b01,
        MODE_CAPTURE_TMR  = 2'b10,
        MODE_CAPTURE_CNT  = 2'b11
    } tt_mode_e;

    function automatic logic tt_mode_runs(input tt_mode_e mode);
        return mode == MODE_RELOAD_TIMER;
    endfunction

endpackage

// File: rtl/tt_gate.sv
module tt_gate
    import toggle_timer_pkg::*;
(
    input  logic tick_en,
    input  logic run,
    input  logic capture_sel,
    input  logic counter_sel,
    output logic advance
);
    tt_mode_e mode;

    always_comb begin
        mode    = tt_mode_e'({capture_sel, counter_sel});
        advance = tick_en & run & tt_mode_runs(mode);
    end
endmodule

// File: rtl/tt_counter.sv
module tt_counter
    import toggle_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             down,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             wrap_now,
    output logic             wrap_q
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wrap;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    tt_dir_e dir;
    logic    at_end;

    always_comb begin
        dir    = tt_dir_e'(down);
        st_d   = st_q;
        at_end = (dir == DIR_DOWN) ? (st_q.cnt == reload) : (st_q.cnt == ALL_ONES);
        st_d.wrap = advance & at_end;
        if (advance) begin
            if (at_end) begin
                st_d.cnt = (dir == DIR_DOWN) ? ALL_ONES : reload;
            end else if (dir == DIR_DOWN) begin
                st_d.cnt = st_q.cnt - ONE;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count    = st_q.cnt;
    assign wrap_now = st_d.wrap;
    assign wrap_q   = st_q.wrap;
endmodule

// File: rtl/tt_toggle.sv
module tt_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    input  logic wr_en,
    input  logic wr_val,
    input  logic oe,
    output logic state,
    output logic pin
);
    typedef struct packed {
        logic lvl;
    } tgl_st_t;

    tgl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.lvl = wr_val;
        end else if (flip) begin
            st_d.lvl = ~st_q.lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q.lvl;
    assign pin   = oe & st_q.lvl;
endmodule

// File: rtl/toggle_timer.sv
module toggle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] cfg_reload,
    input  logic             cfg_down,
    input  logic             cfg_run,
    input  logic             cfg_oe,
    input  logic             cfg_capture_sel,
    input  logic             cfg_counter_sel,
    input  logic             tgl_wr_en,
    input  logic             tgl_wr_val,
    output logic [CNT_W-1:0] count_o,
    output logic             event_o,
    output logic             tgl_state_o,
    output logic             pin_o
);
    logic advance;
    logic wrap_now;

    tt_gate u_gate (
        .tick_en     (tick_en),
        .run         (cfg_run),
        .capture_sel (cfg_capture_sel),
        .counter_sel (cfg_counter_sel),
        .advance     (advance)
    );

    tt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .down     (cfg_down),
        .reload   (cfg_reload),
        .count    (count_o),
        .wrap_now (wrap_now),
        .wrap_q   (event_o)
    );

    tt_toggle u_tgl (
        .clk    (clk),
        .rst_n  (rst_n),
        .flip   (wrap_now),
        .wr_en  (tgl_wr_en),
        .wr_val (tgl_wr_val),
        .oe     (cfg_oe),
        .state  (tgl_state_o),
        .pin    (pin_o)
    );
endmodule

// File: rtl/toggle_timer_chk.sv
module toggle_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic [CNT_W-1:0] cfg_reload,
    input logic             cfg_down,
    input logic             cfg_run,
    input logic             cfg_oe,
    input logic             cfg_capture_sel,
    input logic             cfg_counter_sel,
    input logic             tgl_wr_en,
    input logic             tgl_wr_val,
    input logic [CNT_W-1:0] count_o,
    input logic             event_o,
    input logic             tgl_state_o,
    input logic             pin_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    logic go, up_end, dn_end, fired;
    assign go     = tick_en & cfg_run & ~cfg_capture_sel & ~cfg_counter_sel;
    assign up_end = ~cfg_down & (count_o == ALL_ONES);
    assign dn_end = cfg_down & (count_o == cfg_reload);
    assign fired  = go & (up_end | dn_end);

    a_r1_up_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (go && up_end) |=> (count_o == $past(cfg_reload)));
    a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !cfg_down && !up_end) |=> (count_o == $past(count_o) + ONE));
    a_r2_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (go && dn_end) |=> (count_o == ALL_ONES));
    a_r2_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (go && cfg_down && !dn_end) |=> (count_o == $past(count_o) - ONE));
    a_r3_event_set: assert property (@(posedge clk) disable iff (!rst_n)
        fired |=> event_o);
    a_r3_event_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !fired |=> !event_o);
    a_r4_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && !tgl_wr_en) |=> (tgl_state_o != $past(tgl_state_o)));
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !tgl_wr_en) |=> ($stable(count_o) && $stable(tgl_state_o)));
    a_r7_pin: assert property (@(posedge clk) disable iff (!rst_n)
        pin_o == (cfg_oe & tgl_state_o));
    a_r8_write: assert property (@(posedge clk) disable iff (!rst_n)
        tgl_wr_en |=> (tgl_state_o == $past(tgl_wr_val)));
endmodule

bind toggle_timer toggle_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick_en         (tick_en),
    .cfg_reload      (cfg_reload),
    .cfg_down        (cfg_down),
    .cfg_run         (cfg_run),
    .cfg_oe          (cfg_oe),
    .cfg_capture_sel (cfg_capture_sel),
    .cfg_counter_sel (cfg_counter_sel),
    .tgl_wr_en       (tgl_wr_en),
    .tgl_wr_val      (tgl_wr_val),
    .count_o         (count_o),
    .event_o         (event_o),
    .tgl_state_o     (tgl_state_o),
    .pin_o           (pin_o)
);

// File: tb/toggle_timer_tb.sv
module toggle_timer_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic [W-1:0] cfg_reload = '0;
    logic         cfg_down = 1'b0;
    logic         cfg_run = 1'b0;
    logic         cfg_oe = 1'b0;
    logic         cfg_capture_sel = 1'b0;
    logic         cfg_counter_sel = 1'b0;
    logic         tgl_wr_en = 1'b0;
    logic         tgl_wr_val = 1'b0;
    logic [W-1:0] count_o;
    logic         event_o, tgl_state_o, pin_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    toggle_timer #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_reload(cfg_reload),
        .cfg_down(cfg_down), .cfg_run(cfg_run), .cfg_oe(cfg_oe),
        .cfg_capture_sel(cfg_capture_sel), .cfg_counter_sel(cfg_counter_sel),
        .tgl_wr_en(tgl_wr_en), .tgl_wr_val(tgl_wr_val),
        .count_o(count_o), .event_o(event_o), .tgl_state_o(tgl_state_o), .pin_o(pin_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; cfg_run = 1'b0; tgl_wr_en = 1'b0;
        cfg_capture_sel = 1'b0; cfg_counter_sel = 1'b0; cfg_oe = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // n consecutive ticks, sampled at the negedge after the last one
    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 count", count_o, 0);
        chk("R10 event", event_o, 0);
        chk("R10 tgl", tgl_state_o, 0);
        chk("R10 pin", pin_o, 0);
    endtask

    task automatic t_up();
        do_reset();
        cfg_reload = 8'hF0; cfg_down = 1'b0; cfg_run = 1'b1;
        ticks(255);
        chk("R1 count at top", count_o, 8'hFF);
        chk("R3 no event before wrap", event_o, 0);
        ticks(1);
        chk("R1 reload", count_o, 8'hF0);
        chk("R3 event pulse", event_o, 1);
        chk("R4 flip up", tgl_state_o, 1);
        @(negedge clk);
        chk("R3 event single cycle", event_o, 0);
        ticks(1);
        chk("R1 increment", count_o, 8'hF1);
        ticks(14);
        chk("R5 up no early flip", tgl_state_o, 1);
        ticks(1);
        chk("R5 up half period 16", tgl_state_o, 0);
        chk("R1 second reload", count_o, 8'hF0);
    endtask

    task automatic t_down();
        do_reset();
        cfg_reload = 8'hF8; cfg_down = 1'b1; cfg_run = 1'b1;
        ticks(1);
        chk("R2 wrap 0 to ones", count_o, 8'hFF);
        chk("R3 no event on plain wrap", event_o, 0);
        ticks(7);
        chk("R2 decrement to match", count_o, 8'hF8);
        ticks(1);
        chk("R2 reload ones", count_o, 8'hFF);
        chk("R3 down event", event_o, 1);
        chk("R4 flip down", tgl_state_o, 1);
        ticks(7);
        chk("R5 down no early flip", tgl_state_o, 1);
        ticks(1);
        chk("R5 down half period 8", tgl_state_o, 0);
    endtask

    task automatic t_hold();
        logic [W-1:0] c0;
        do_reset();
        cfg_reload = 8'h00; cfg_down = 1'b0; cfg_run = 1'b1;
        ticks(5);
        c0 = count_o;
        chk("R6 baseline", c0, 5);
        cfg_run = 1'b0; ticks(3);
        chk("R6 run off holds", count_o, c0);
        cfg_run = 1'b1; cfg_capture_sel = 1'b1; ticks(3);
        chk("R6 capture mode holds", count_o, c0);
        cfg_capture_sel = 1'b0; cfg_counter_sel = 1'b1; ticks(3);
        chk("R6 counter mode holds", count_o, c0);
        cfg_counter_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 no tick holds", count_o, c0);
        // tick every other cycle: 4 ticks over 8 cycles
        for (int i = 0; i < 8; i++) begin
            tick_en = (i % 2 == 0);
            @(negedge clk);
        end
        tick_en = 1'b0;
        chk("R6 sparse ticks", count_o, c0 + 4);
    endtask

    task automatic t_pin_force();
        do_reset();
        tgl_wr_en = 1'b1; tgl_wr_val = 1'b1;
        @(negedge clk);
        tgl_wr_en = 1'b0;
        chk("R8 force high", tgl_state_o, 1);
        chk("R7 pin low when disabled", pin_o, 0);
        cfg_oe = 1'b1; #1;
        chk("R7 pin follows state", pin_o, 1);
        tgl_wr_en = 1'b1; tgl_wr_val = 1'b0;
        @(negedge clk);
        tgl_wr_en = 1'b0;
        chk("R8 force low", tgl_state_o, 0);
        chk("R7 pin low with state", pin_o, 0);
        // collision: up mode, reach all-ones, write 0 on the reloading tick
        cfg_reload = 8'hC0; cfg_down = 1'b0; cfg_run = 1'b1;
        ticks(255);
        chk("R8 setup at top", count_o, 8'hFF);
        tgl_wr_en = 1'b1; tgl_wr_val = 1'b0;
        ticks(1);
        tgl_wr_en = 1'b0;
        chk("R8 write beats flip", tgl_state_o, 0);
        chk("R8 reload still occurs", count_o, 8'hC0);
        chk("R3 event on collision", event_o, 1);
    endtask

    task automatic t_dir();
        do_reset();
        cfg_reload = 8'h00; cfg_down = 1'b0; cfg_run = 1'b1;
        ticks(64);
        chk("R9 up to 0x40", count_o, 8'h40);
        cfg_down = 1'b1;
        @(negedge clk);
        chk("R9 switch keeps count", count_o, 8'h40);
        ticks(1);
        chk("R9 next tick steps down", count_o, 8'h3F);
        cfg_down = 1'b0;
        ticks(2);
        chk("R9 back up", count_o, 8'h41);
    endtask

    initial begin
        t_reset();
        t_up();
        t_down();
        t_hold();
        t_pin_force();
        t_dir();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule